// File: doc/BRIEF.md
# Synchronous Burst Address Generator

This block sits at the address input of a synchronous burst memory. Every rising clock edge samples an external word address, two chip enables, two burst-start strobes, an advance input, a beat-order mode input and a write request. From these it keeps a registered internal word address for the memory core. It also keeps a flag that says the address belongs to a selected access, and a qualifier that marks the access as a write.

A burst covers four beats that differ only in the two low address bits. A burst is started by one of two strobes. One is meant for a host processor and the other for a memory controller. Each strobe loads a fresh external address. While the advance input is held high, later beats come from an internal beat counter. The mode input picks linear order, where the low bits count up and wrap. It can instead pick interleaved order, where the low bits are the start bits XORed with the beat number. A fresh address may be loaded on any cycle, so bursting is optional.

Every output is registered. The response to the inputs sampled at one rising edge is visible just after that edge.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rstN` is low, `beatAddr` is 0, `accessValid` is 0 and `accessWrite` is 0.
- R2: A start strobe taken while both `enPrimary` and `enSecondary` are high loads `extAddr` into `beatAddr` after that edge and sets `accessValid`. A load is accepted on every cycle, including back to back.
- R3: With `interleaveMode` = 0, each advance makes the two low bits of `beatAddr` equal to (start low bits + beat number) mod 4. The beat number is 1, 2, 3 and then 0 again. The upper bits stay equal to the loaded value.
- R4: With `interleaveMode` = 1, each advance makes the two low bits equal to the start low bits XOR the beat number. The upper bits are unchanged.
- R5: `beatAdvance` steps the beat only while `accessValid` is 1 and no strobe is taken. When there is no taken strobe and no step, `beatAddr`, `accessValid` and `accessWrite` hold their values.
- R6: When `hostStart` and `ctrlStart` are both high and `enPrimary` is high, the host strobe is the one acted on.
- R7: `hostStart` is ignored while `enPrimary` is low. The cycle then behaves as if `hostStart` were low.
- R8: A taken strobe with either enable low is a deselect. `accessValid` and `accessWrite` go to 0 and `beatAddr` holds its value.
- R9: A load through `hostStart` clears `accessWrite`. A load through `ctrlStart` sets `accessWrite` to `writeReq`. Advances keep `accessWrite` unchanged.
- R10: A load issued in the middle of a burst ends that burst. The next beats count from the newly loaded address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| extAddr | input | ADDR_W | External word address |
| enPrimary | input | 1 | Primary chip enable, active high; also gates `hostStart` |
| enSecondary | input | 1 | Secondary chip enable, active high |
| hostStart | input | 1 | Processor-side burst start strobe |
| ctrlStart | input | 1 | Controller-side burst start strobe |
| beatAdvance | input | 1 | Step to the next beat of the burst |
| interleaveMode | input | 1 | 0 = linear beat order, 1 = interleaved beat order |
| writeReq | input | 1 | Write request captured with a controller-side load |
| beatAddr | output | ADDR_W | Internal word address of the current beat |
| accessValid | output | 1 | Current address belongs to a selected access |
| accessWrite | output | 1 | Current access is a write |

## Verification
The bench builds the block with an 8-bit address and the default 2-bit beat counter. At this width, upper bits and low bits appear together as two hex digits. That makes it plain that the upper bits survive every wrap, and the table can name each expected address directly. The table covers all four start offsets in both beat orders. It also covers a reload in the middle of a burst, back-to-back loads, the strobe priority, and each way a cycle can deselect or be ignored. A reset applied in the middle of a burst is then checked directly.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  // Strobes from the control module to the address datapath
  typedef struct packed {
    logic load;   // capture a fresh external address, restart the beat count
    logic step;   // move to the next beat of the current burst
  } dpCtl_t;

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_addr_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   enPrimary,
  input  logic   enSecondary,
  input  logic   hostStart,
  input  logic   ctrlStart,
  input  logic   beatAdvance,
  input  logic   writeReq,
  output dpCtl_t dpCtl,
  output logic   accessValid,
  output logic   accessWrite
);

  logic hostTake;
  logic ctrlTake;
  logic anyTake;
  logic selected;
  logic validQ;
  logic writeQ;

  // The host strobe counts only with the primary enable and wins over the controller strobe
  assign hostTake = hostStart & enPrimary;
  assign ctrlTake = ctrlStart & ~hostTake;
  assign anyTake  = hostTake | ctrlTake;
  assign selected = enPrimary & enSecondary;

  always_comb begin
    dpCtl      = '0;
    dpCtl.load = anyTake & selected;
    dpCtl.step = ~anyTake & beatAdvance & validQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
      writeQ <= 1'b0;
    end else if (anyTake) begin
      validQ <= selected;
      writeQ <= selected & ctrlTake & writeReq;
    end
  end

  assign accessValid = validQ;
  assign accessWrite = writeQ;

endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic              interleaveMode,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] beatAddr
);

  localparam int UPPER_W = ADDR_W - BURST_BITS;

  logic [ADDR_W-1:0]     curAddrQ;
  logic [BURST_BITS-1:0] startLowQ;
  logic [BURST_BITS-1:0] beatQ;
  logic [BURST_BITS-1:0] beatNext;
  logic [BURST_BITS-1:0] lowNext;

  assign beatNext = beatQ + 1'b1;

  // Beat order: modular sum for linear order, XOR for interleaved order
  always_comb begin
    if (interleaveMode) lowNext = startLowQ ^ beatNext;
    else                lowNext = startLowQ + beatNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddrQ  <= '0;
      startLowQ <= '0;
      beatQ     <= '0;
    end else if (dpCtl.load) begin
      curAddrQ  <= extAddr;
      startLowQ <= extAddr[BURST_BITS-1:0];
      beatQ     <= '0;
    end else if (dpCtl.step) begin
      curAddrQ  <= {curAddrQ[ADDR_W-1 -: UPPER_W], lowNext};
      beatQ     <= beatNext;
    end
  end

  assign beatAddr = curAddrQ;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              enPrimary,
  input  logic              enSecondary,
  input  logic              hostStart,
  input  logic              ctrlStart,
  input  logic              beatAdvance,
  input  logic              interleaveMode,
  input  logic              writeReq,
  output logic [ADDR_W-1:0] beatAddr,
  output logic              accessValid,
  output logic              accessWrite
);

  dpCtl_t dpCtl;

  burst_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .enPrimary   (enPrimary),
    .enSecondary (enSecondary),
    .hostStart   (hostStart),
    .ctrlStart   (ctrlStart),
    .beatAdvance (beatAdvance),
    .writeReq    (writeReq),
    .dpCtl       (dpCtl),
    .accessValid (accessValid),
    .accessWrite (accessWrite)
  );

  burst_datapath #(
    .ADDR_W     (ADDR_W),
    .BURST_BITS (BURST_BITS)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .dpCtl          (dpCtl),
    .interleaveMode (interleaveMode),
    .extAddr        (extAddr),
    .beatAddr       (beatAddr)
  );

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W     = 18,
  parameter int BURST_BITS = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] extAddr,
  input logic              enPrimary,
  input logic              enSecondary,
  input logic              hostStart,
  input logic              ctrlStart,
  input logic              beatAdvance,
  input logic              writeReq,
  input logic [ADDR_W-1:0] beatAddr,
  input logic              accessValid,
  input logic              accessWrite
);

  logic hostIn;
  logic ctrlIn;
  logic noStrobe;

  assign hostIn   = hostStart & enPrimary;
  assign ctrlIn   = ctrlStart & ~hostIn;
  assign noStrobe = ~hostIn & ~ctrlStart;

  // R1: outputs at their reset values while reset is held
  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_state_r1: assert (beatAddr == '0 && !accessValid && !accessWrite)
        else $error("reset state wrong");
    end
  end

  // R2, R10: a selected load shows the external address on the next cycle
  p_load_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((hostIn || ctrlStart) && enPrimary && enSecondary)
      |=> (accessValid && beatAddr == $past(extAddr)));

  // R3, R4: stepping keeps the upper bits
  p_upper_kept_r3: assert property (@(posedge clk) disable iff (!rstN)
    (noStrobe && beatAdvance && accessValid)
      |=> (beatAddr[ADDR_W-1:BURST_BITS] == $past(beatAddr[ADDR_W-1:BURST_BITS])));

  // R5: no strobe and no advance holds everything
  p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (noStrobe && !beatAdvance)
      |=> ($stable(beatAddr) && $stable(accessValid) && $stable(accessWrite)));

  // R8: deselect clears the flags and holds the address
  p_deselect_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((hostIn || ctrlStart) && !(enPrimary && enSecondary))
      |=> (!accessValid && !accessWrite && $stable(beatAddr)));

  // R9, R6: a host load is a read
  p_host_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    (hostIn && enSecondary) |=> !accessWrite);

  // R9: a controller load takes the write request
  p_ctrl_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlIn && enPrimary && enSecondary) |=> (accessWrite == $past(writeReq)));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(
  .ADDR_W     (ADDR_W),
  .BURST_BITS (BURST_BITS)
) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .extAddr     (extAddr),
  .enPrimary   (enPrimary),
  .enSecondary (enSecondary),
  .hostStart   (hostStart),
  .ctrlStart   (ctrlStart),
  .beatAdvance (beatAdvance),
  .writeReq    (writeReq),
  .beatAddr    (beatAddr),
  .accessValid (accessValid),
  .accessWrite (accessWrite)
);

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;

  localparam int AW = 8;
  localparam int NV = 47;

  // Vector: {host, ctrl, adv, enP, enS, mode, wr} , extAddr , expAddr , {expValid, expWrite}
  localparam logic [24:0] VEC [NV] = '{
    // R3 linear, start offset 0, controller write
    {7'b0101101, 8'h40, 8'h40, 2'b11},
    {7'b0011100, 8'h00, 8'h41, 2'b11},
    {7'b0011100, 8'h00, 8'h42, 2'b11},
    {7'b0011100, 8'h00, 8'h43, 2'b11},
    {7'b0011100, 8'h00, 8'h40, 2'b11},
    // R3 linear, offset 1, host
    {7'b1001100, 8'h55, 8'h55, 2'b10},
    {7'b0011100, 8'h00, 8'h56, 2'b10},
    {7'b0011100, 8'h00, 8'h57, 2'b10},
    {7'b0011100, 8'h00, 8'h54, 2'b10},
    // R3 linear, offset 2, controller read
    {7'b0101100, 8'h7A, 8'h7A, 2'b10},
    {7'b0011100, 8'h00, 8'h7B, 2'b10},
    {7'b0011100, 8'h00, 8'h78, 2'b10},
    {7'b0011100, 8'h00, 8'h79, 2'b10},
    // R3 linear, offset 3
    {7'b1001100, 8'h93, 8'h93, 2'b10},
    {7'b0011100, 8'h00, 8'h90, 2'b10},
    {7'b0011100, 8'h00, 8'h91, 2'b10},
    {7'b0011100, 8'h00, 8'h92, 2'b10},
    // R4 interleaved, offset 0
    {7'b1001110, 8'hA0, 8'hA0, 2'b10},
    {7'b0011110, 8'h00, 8'hA1, 2'b10},
    {7'b0011110, 8'h00, 8'hA2, 2'b10},
    {7'b0011110, 8'h00, 8'hA3, 2'b10},
    // R4 interleaved, offset 1
    {7'b1001110, 8'hB5, 8'hB5, 2'b10},
    {7'b0011110, 8'h00, 8'hB4, 2'b10},
    {7'b0011110, 8'h00, 8'hB7, 2'b10},
    {7'b0011110, 8'h00, 8'hB6, 2'b10},
    // R4 interleaved, offset 2, controller write
    {7'b0101111, 8'hC6, 8'hC6, 2'b11},
    {7'b0011110, 8'h00, 8'hC7, 2'b11},
    {7'b0011110, 8'h00, 8'hC4, 2'b11},
    {7'b0011110, 8'h00, 8'hC5, 2'b11},
    // R4 interleaved, offset 3
    {7'b1001110, 8'hDB, 8'hDB, 2'b10},
    {7'b0011110, 8'h00, 8'hDA, 2'b10},
    {7'b0011110, 8'h00, 8'hD9, 2'b10},
    {7'b0011110, 8'h00, 8'hD8, 2'b10},
    // R10 reload mid-burst
    {7'b0101100, 8'h20, 8'h20, 2'b10},
    {7'b0011100, 8'h00, 8'h21, 2'b10},
    {7'b1001100, 8'hE2, 8'hE2, 2'b10},
    {7'b0011100, 8'h00, 8'hE3, 2'b10},
    {7'b0011100, 8'h00, 8'hE0, 2'b10},
    // R5 idle hold
    {7'b0001100, 8'h77, 8'hE0, 2'b10},
    // R6 host wins over controller (write request ignored)
    {7'b1101101, 8'h30, 8'h30, 2'b10},
    // R7 host ignored with primary enable low; advance still steps
    {7'b1010100, 8'h99, 8'h31, 2'b10},
    // R8 host with secondary enable low deselects
    {7'b1001000, 8'h66, 8'h31, 2'b00},
    // R5 advance ignored while not valid
    {7'b0011100, 8'h00, 8'h31, 2'b00},
    // R9 controller write load, then R8 controller deselect
    {7'b0101101, 8'h12, 8'h12, 2'b11},
    {7'b0100101, 8'h88, 8'h12, 2'b00},
    // R2 back-to-back loads
    {7'b0101101, 8'h44, 8'h44, 2'b11},
    {7'b1001100, 8'h45, 8'h45, 2'b10}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] extAddr = '0;
  logic          enPrimary = 1'b0;
  logic          enSecondary = 1'b0;
  logic          hostStart = 1'b0;
  logic          ctrlStart = 1'b0;
  logic          beatAdvance = 1'b0;
  logic          interleaveMode = 1'b0;
  logic          writeReq = 1'b0;
  logic [AW-1:0] beatAddr;
  logic          accessValid;
  logic          accessWrite;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .BURST_BITS(2)) i_burst_addr_gen (
    .clk(clk), .rstN(rstN), .extAddr(extAddr),
    .enPrimary(enPrimary), .enSecondary(enSecondary),
    .hostStart(hostStart), .ctrlStart(ctrlStart),
    .beatAdvance(beatAdvance), .interleaveMode(interleaveMode),
    .writeReq(writeReq), .beatAddr(beatAddr),
    .accessValid(accessValid), .accessWrite(accessWrite)
  );

  task automatic checkOut(input string req, input logic [AW-1:0] expA,
                          input logic expV, input logic expW);
    testCount++;
    if (beatAddr !== expA || accessValid !== expV || accessWrite !== expW) begin
      failCount++;
      $display("FAIL %s: addr=%h valid=%b write=%b expected addr=%h valid=%b write=%b",
               req, beatAddr, accessValid, accessWrite, expA, expV, expW);
    end
  endtask

  initial begin
    #100000;
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkOut("R1", 8'h00, 1'b0, 1'b0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {hostStart, ctrlStart, beatAdvance, enPrimary, enSecondary,
       interleaveMode, writeReq} = VEC[i][24:18];
      extAddr = VEC[i][17:10];
      @(posedge clk);
      #1;
      checkOut($sformatf("R2-table row %0d", i), VEC[i][9:2], VEC[i][1], VEC[i][0]);
    end

    // R1: reset in the middle of a burst
    @(negedge clk);
    {hostStart, ctrlStart, beatAdvance, enPrimary, enSecondary,
     interleaveMode, writeReq} = 7'b0101101;
    extAddr = 8'h6D;
    @(posedge clk);
    #1;
    checkOut("R2", 8'h6D, 1'b1, 1'b1);
    @(negedge clk);
    {hostStart, ctrlStart, beatAdvance} = 3'b001;
    rstN = 1'b0;
    #1;
    checkOut("R1", 8'h00, 1'b0, 1'b0);
    @(posedge clk);
    #1;
    checkOut("R1", 8'h00, 1'b0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    checkOut("R5", 8'h00, 1'b0, 1'b0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule